// File: doc/BRIEF.md
# Converter Channel Trigger Arbiter

This block decides which converter channel is sampled next. Each channel owns a small configuration word. The word names where the channel's trigger comes from, gives its priority, marks whether the channel closes a group, and carries a done-level bit. Triggers can come from a per-channel timer input or from one of five shared generic inputs. A channel can also be set as continuous, which means it is always waiting.

Trigger pulses are latched as pending requests. When no conversion group is active, the arbiter grants one pending channel. It first finds the most urgent priority level that has any request. Among the waiting channels of that level it then rotates, keeping one rotation pointer per level. The granted channel is the group head. Each conversion-complete pulse moves the grant to the next channel index. This continues until the channel whose group-end flag is set has completed. At that point the head's request is cleared and the rotation pointer of its level moves on.

Top module: `conv_trig_arbiter`

## Requirements
- R1: After a synchronous reset, `gnt_valid` and `multi_cont_err` are 0. Every channel configuration reads back 0x40. Configuration word layout: bits [2:0] are the trigger source, bits [5:3] the priority, bit 6 the group-end flag and bit 7 the done-level bit.
- R2: A configuration write is ignored when `blk_en` is 1 and the target channel's `ch_en` bit is 1. When either is 0 the write takes effect. `cfg_rd_data` returns the configuration of channel `cfg_rd_ch` one cycle after the read is requested.
- R3: Trigger source 1 selects the channel's own `tmr_trig` bit. A one-cycle pulse on an enabled head channel, with the block idle, gives `gnt_valid`=1 and `gnt_ch` equal to that channel on the second rising edge after the pulse is applied.
- R4: Trigger sources 2 to 6 select `gen_trig[0]` to `gen_trig[4]`. A pulse on any other generic input does not make the channel pending.
- R5: Priority value 0 is the most urgent and 7 the least. The grant always goes to a channel of the most urgent level that has a request, whatever its index.
- R6: Within one level, the grant goes to the lowest-indexed waiting channel at or above that level's pointer. If there is none, it goes to the lowest-indexed waiting channel of the level. After a group finishes, the level's pointer becomes the head index plus one, wrapping to 0.
- R7: While granted, each `conv_done` pulse moves `gnt_ch` to the next index. When `conv_done` arrives for a channel whose group-end flag is set, or for the highest index, `gnt_valid` drops on that edge. A new grant can appear on the following edge.
- R8: Trigger source 7 (continuous) keeps an enabled channel pending without any trigger. The channel is granted again right after each of its groups completes.
- R9: `multi_cont_err` is 1 one cycle after more than one channel is configured as continuous, and 0 one cycle after at most one is.
- R10: Channels that are disabled (`blk_en`=0 or their `ch_en` bit 0), and channels with trigger source 0, never latch a request and are never granted. A request latched earlier does not survive disabling.
- R11: While `gnt_valid` is 1 and `conv_done` is 0, `gnt_ch` and `gnt_valid` hold. New triggers are latched but do not interrupt the current group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| blk_en | input | 1 | Whole-block enable |
| ch_en | input | NUM_CH | Per-channel enable |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wr_ch | input | CW | Channel to write |
| cfg_wr_data | input | 8 | Configuration word to write |
| cfg_rd_ch | input | CW | Channel to read back |
| cfg_rd_data | output | 8 | Registered configuration read data |
| tmr_trig | input | NUM_CH | Per-channel timer trigger pulses |
| gen_trig | input | NUM_GEN | Shared generic trigger pulses |
| conv_done | input | 1 | Conversion of the granted channel has completed |
| gnt_valid | output | 1 | A channel is granted |
| gnt_ch | output | CW | Index of the granted channel |
| multi_cont_err | output | 1 | More than one channel is set to continuous |

## Verification
The bench targets the rotation pointer. It re-triggers a level while one of its channels is still converting, so the next grant must skip the lower index that a plain lowest-index picker would return. A later grant then checks the wrap-around. Group stepping is checked with a second head triggered mid-group: a design that arbitrates early would break into the group, and one that ignores the group-end flag would run on to the wrong index. Further cases cover a stale request kept across a disable, which would give a spurious grant, and a generic trigger decoded off by one, which would answer to the wrong input. Write gating is checked by reading configuration back after writes made under each enable combination.

// File: rtl/cta_pkg.sv
package cta_pkg;
  typedef logic [2:0] sel_t;
  typedef logic [2:0] prio_t;

  typedef struct packed {
    logic  done_lvl;
    logic  grp_end;
    prio_t prio;
    sel_t  sel;
  } ch_cfg_t;

  localparam sel_t SEL_OFF  = 3'd0;
  localparam sel_t SEL_TMR  = 3'd1;
  localparam sel_t SEL_GEN0 = 3'd2;
  localparam sel_t SEL_CONT = 3'd7;
  localparam int   NUM_LVL  = 8;

  localparam ch_cfg_t CFG_RST = '{done_lvl: 1'b0, grp_end: 1'b1, prio: 3'd0, sel: SEL_OFF};
endpackage

// File: rtl/cta_cfg_bank.sv
module cta_cfg_bank
  import cta_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CW     = $clog2(NUM_CH)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 blk_en,
  input  logic [NUM_CH-1:0]    ch_en,
  input  logic                 wr_en,
  input  logic [CW-1:0]        wr_ch,
  input  ch_cfg_t              wr_data,
  input  logic [CW-1:0]        rd_ch,
  output ch_cfg_t              rd_data,
  output sel_t  [NUM_CH-1:0]   sel_o,
  output prio_t [NUM_CH-1:0]   prio_o,
  output logic  [NUM_CH-1:0]   gend_o
);
  ch_cfg_t [NUM_CH-1:0] cfg_q;
  logic                 wr_ok;

  // writes only land on a channel that is not running
  assign wr_ok = wr_en && (!blk_en || !ch_en[wr_ch]);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_CH; i++) cfg_q[i] <= CFG_RST;
      rd_data <= CFG_RST;
    end else begin
      if (wr_ok) cfg_q[wr_ch] <= wr_data;
      rd_data <= cfg_q[rd_ch];
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_fld
    assign sel_o[g]  = cfg_q[g].sel;
    assign prio_o[g] = cfg_q[g].prio;
    assign gend_o[g] = cfg_q[g].grp_end;

    // R2: an enabled channel's configuration cannot change
    a_r2_locked: assert property (@(posedge clk) disable iff (rst)
      (blk_en && ch_en[g]) |=> $stable(cfg_q[g]));
  end
endmodule

// File: rtl/cta_pend.sv
module cta_pend
  import cta_pkg::*;
#(
  parameter int NUM_CH  = 8,
  parameter int NUM_GEN = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  sel_t [NUM_CH-1:0]   sel,
  input  logic [NUM_CH-1:0]   en_mask,
  input  logic [NUM_CH-1:0]   tmr_trig,
  input  logic [NUM_GEN-1:0]  gen_trig,
  input  logic [NUM_CH-1:0]   clr,
  output logic [NUM_CH-1:0]   pend_o
);
  logic [NUM_CH-1:0] hit;
  logic [NUM_CH-1:0] pend_q;

  always_comb begin
    hit = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (sel[i] == SEL_TMR) begin
        hit[i] = tmr_trig[i];
      end else if (sel[i] != SEL_OFF && sel[i] != SEL_CONT) begin
        for (int k = 0; k < NUM_GEN; k++)
          if (int'(sel[i]) - int'(SEL_GEN0) == k) hit[i] = gen_trig[k];
      end
    end
  end

  // a trigger in the clearing cycle wins, so it is not lost
  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= ((pend_q & ~clr) | hit) & en_mask;
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_out
    assign pend_o[g] = en_mask[g] && (pend_q[g] || sel[g] == SEL_CONT);

    // R3: a timer pulse on an enabled timer channel is latched
    a_r3_latch: assert property (@(posedge clk) disable iff (rst)
      (en_mask[g] && sel[g] == SEL_TMR && tmr_trig[g]) |=> (pend_o[g] || !en_mask[g]));
  end
endmodule

// File: rtl/cta_pick.sv
module cta_pick
  import cta_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CW     = $clog2(NUM_CH)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_CH-1:0]   req,
  input  prio_t [NUM_CH-1:0]  prio,
  input  logic                adv,
  input  logic [CW-1:0]       adv_ch,
  output logic                win_valid,
  output logic [CW-1:0]       win_ch
);
  logic [CW-1:0]      ptr_q [NUM_LVL];
  logic [NUM_LVL-1:0] lvl_hit;
  prio_t              best;
  logic [NUM_CH-1:0]  cand;

  always_comb begin
    lvl_hit = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (req[i]) lvl_hit[prio[i]] = 1'b1;
    best = '0;
    for (int l = NUM_LVL - 1; l >= 0; l--)
      if (lvl_hit[l]) best = 3'(l);
    for (int i = 0; i < NUM_CH; i++)
      cand[i] = req[i] && (prio[i] == best);
    win_valid = |cand;
    win_ch    = '0;
    // lowest candidate overall, then overridden by lowest at or above pointer
    for (int i = NUM_CH - 1; i >= 0; i--)
      if (cand[i]) win_ch = CW'(i);
    for (int i = NUM_CH - 1; i >= 0; i--)
      if (cand[i] && i >= int'(ptr_q[best])) win_ch = CW'(i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int l = 0; l < NUM_LVL; l++) ptr_q[l] <= '0;
    end else if (adv) begin
      ptr_q[prio[adv_ch]] <= (int'(adv_ch) == NUM_CH - 1) ? '0 : adv_ch + 1'b1;
    end
  end

  always_comb begin
    if (!rst && win_valid) begin
      a_r10_win_pending: assert (req[win_ch]);
      for (int i = 0; i < NUM_CH; i++)
        if (req[i]) begin
          a_r5_best_level: assert (prio[win_ch] <= prio[i]);
        end
    end
  end
endmodule

// File: rtl/conv_trig_arbiter.sv
module conv_trig_arbiter
  import cta_pkg::*;
#(
  parameter int NUM_CH  = 8,
  parameter int NUM_GEN = 5,
  parameter int CW      = $clog2(NUM_CH)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               blk_en,
  input  logic [NUM_CH-1:0]  ch_en,
  input  logic               cfg_we,
  input  logic [CW-1:0]      cfg_wr_ch,
  input  logic [7:0]         cfg_wr_data,
  input  logic [CW-1:0]      cfg_rd_ch,
  output logic [7:0]         cfg_rd_data,
  input  logic [NUM_CH-1:0]  tmr_trig,
  input  logic [NUM_GEN-1:0] gen_trig,
  input  logic               conv_done,
  output logic               gnt_valid,
  output logic [CW-1:0]      gnt_ch,
  output logic               multi_cont_err
);
  sel_t  [NUM_CH-1:0] sel;
  prio_t [NUM_CH-1:0] prio;
  logic  [NUM_CH-1:0] gend;
  ch_cfg_t            rd_cfg;
  logic  [NUM_CH-1:0] en_mask, pend, clr, cont_vec;
  logic               win_valid, last_ch, grp_fin;
  logic  [CW-1:0]     win_ch, head_q, gnt_ch_q;
  logic               gnt_valid_q, err_q;
  int unsigned        cont_cnt;

  assign en_mask = blk_en ? ch_en : '0;

  cta_cfg_bank #(.NUM_CH(NUM_CH), .CW(CW)) u_cfg (
    .clk(clk), .rst(rst), .blk_en(blk_en), .ch_en(ch_en),
    .wr_en(cfg_we), .wr_ch(cfg_wr_ch), .wr_data(ch_cfg_t'(cfg_wr_data)),
    .rd_ch(cfg_rd_ch), .rd_data(rd_cfg),
    .sel_o(sel), .prio_o(prio), .gend_o(gend)
  );
  assign cfg_rd_data = rd_cfg;

  cta_pend #(.NUM_CH(NUM_CH), .NUM_GEN(NUM_GEN)) u_pend (
    .clk(clk), .rst(rst), .sel(sel), .en_mask(en_mask),
    .tmr_trig(tmr_trig), .gen_trig(gen_trig), .clr(clr), .pend_o(pend)
  );

  cta_pick #(.NUM_CH(NUM_CH), .CW(CW)) u_pick (
    .clk(clk), .rst(rst), .req(pend), .prio(prio),
    .adv(grp_fin), .adv_ch(head_q),
    .win_valid(win_valid), .win_ch(win_ch)
  );

  assign last_ch = gend[gnt_ch_q] || (int'(gnt_ch_q) == NUM_CH - 1);
  assign grp_fin = gnt_valid_q && conv_done && last_ch && blk_en;
  assign clr     = grp_fin ? (NUM_CH'(1) << head_q) : '0;

  always_comb begin
    cont_cnt = 0;
    for (int i = 0; i < NUM_CH; i++) begin
      cont_vec[i] = (sel[i] == SEL_CONT);
      cont_cnt    = cont_cnt + {31'd0, cont_vec[i]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_valid_q <= 1'b0;
      gnt_ch_q    <= '0;
      head_q      <= '0;
      err_q       <= 1'b0;
    end else begin
      err_q <= (cont_cnt > 1);
      if (!blk_en) begin
        gnt_valid_q <= 1'b0;
      end else if (gnt_valid_q) begin
        if (conv_done) begin
          if (last_ch) gnt_valid_q <= 1'b0;
          else         gnt_ch_q    <= gnt_ch_q + 1'b1;
        end
      end else if (win_valid) begin
        gnt_valid_q <= 1'b1;
        gnt_ch_q    <= win_ch;
        head_q      <= win_ch;
      end
    end
  end

  assign gnt_valid      = gnt_valid_q;
  assign gnt_ch         = gnt_ch_q;
  assign multi_cont_err = err_q;

  // R11: grant holds until the conversion completes
  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    (gnt_valid && !conv_done && blk_en) |=> (gnt_valid && $stable(gnt_ch)));
  // R7: a non-final member hands over to the next index
  a_r7_step: assert property (@(posedge clk) disable iff (rst)
    (gnt_valid && conv_done && blk_en && !gend[gnt_ch] && int'(gnt_ch) != NUM_CH - 1)
    |=> (gnt_valid && gnt_ch == $past(gnt_ch) + 1'b1));
  // R7: completion of the group-end channel releases the grant
  a_r7_end: assert property (@(posedge clk) disable iff (rst)
    (gnt_valid && conv_done && gend[gnt_ch]) |=> !gnt_valid);
  // R9: error flag follows the continuous-channel count
  a_r9_err: assert property (@(posedge clk) disable iff (rst)
    ($countones(cont_vec) > 1) |=> multi_cont_err);
  a_r9_clear: assert property (@(posedge clk) disable iff (rst)
    ($countones(cont_vec) <= 1) |=> !multi_cont_err);
endmodule

// File: tb/test_conv_trig_arbiter.sv
module test_conv_trig_arbiter;
  localparam int NUM_CH  = 8;
  localparam int NUM_GEN = 5;
  localparam int CW      = $clog2(NUM_CH);

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               blk_en = 1'b0;
  logic [NUM_CH-1:0]  ch_en = '0;
  logic               cfg_we = 1'b0;
  logic [CW-1:0]      cfg_wr_ch = '0;
  logic [7:0]         cfg_wr_data = '0;
  logic [CW-1:0]      cfg_rd_ch = '0;
  logic [7:0]         cfg_rd_data;
  logic [NUM_CH-1:0]  tmr_trig = '0;
  logic [NUM_GEN-1:0] gen_trig = '0;
  logic               conv_done = 1'b0;
  logic               gnt_valid;
  logic [CW-1:0]      gnt_ch;
  logic               multi_cont_err;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  conv_trig_arbiter #(.NUM_CH(NUM_CH), .NUM_GEN(NUM_GEN)) i_conv_trig_arbiter (
    .clk(clk), .rst(rst), .blk_en(blk_en), .ch_en(ch_en),
    .cfg_we(cfg_we), .cfg_wr_ch(cfg_wr_ch), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_ch(cfg_rd_ch), .cfg_rd_data(cfg_rd_data),
    .tmr_trig(tmr_trig), .gen_trig(gen_trig), .conv_done(conv_done),
    .gnt_valid(gnt_valid), .gnt_ch(gnt_ch), .multi_cont_err(multi_cont_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chk_gnt(input string tag, input logic v, input int ch);
    chk({tag, " valid"}, 32'(gnt_valid), 32'(v));
    if (v) chk({tag, " channel"}, 32'(gnt_ch), 32'(ch));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; blk_en = 1'b0; ch_en = '0; cfg_we = 1'b0;
    tmr_trig = '0; gen_trig = '0; conv_done = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic cfg_wr(input int ch, input logic [7:0] d);
    cfg_we = 1'b1; cfg_wr_ch = CW'(ch); cfg_wr_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_rd(input int ch, output logic [7:0] d);
    cfg_rd_ch = CW'(ch);
    @(negedge clk);
    d = cfg_rd_data;
  endtask

  task automatic tmr_pulse(input int ch);
    tmr_trig[ch] = 1'b1;
    @(negedge clk);
    tmr_trig = '0;
  endtask

  task automatic gen_pulse(input int g);
    gen_trig[g] = 1'b1;
    @(negedge clk);
    gen_trig = '0;
  endtask

  task automatic done_pulse();
    conv_done = 1'b1;
    @(negedge clk);
    conv_done = 1'b0;
  endtask

  task automatic go();
    blk_en = 1'b1; ch_en = '1;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    do_reset();
    chk("R1 valid after reset", 32'(gnt_valid), 0);
    chk("R1 err after reset", 32'(multi_cont_err), 0);
    cfg_rd(0, d); chk("R1 cfg0 reset", 32'(d), 32'h40);
    cfg_rd(7, d); chk("R1 cfg7 reset", 32'(d), 32'h40);
  endtask

  task automatic t_cfg_gate();
    logic [7:0] d;
    do_reset();
    go();
    cfg_wr(2, 8'h09); cfg_rd(2, d);
    chk("R2 write to running channel ignored", 32'(d), 32'h40);
    ch_en[2] = 1'b0;
    cfg_wr(2, 8'h09); cfg_rd(2, d);
    chk("R2 write to disabled channel", 32'(d), 32'h09);
    blk_en = 1'b0; ch_en = '1;
    cfg_wr(3, 8'h2A); cfg_rd(3, d);
    chk("R2 write with block disabled", 32'(d), 32'h2A);
  endtask

  task automatic t_timer();
    do_reset();
    cfg_wr(3, 8'h51);
    go();
    tmr_pulse(3);
    @(negedge clk); chk_gnt("R3 timer grant", 1'b1, 3);
    repeat (2) @(negedge clk); chk_gnt("R11 hold", 1'b1, 3);
    done_pulse(); chk_gnt("R7 single-member group ends", 1'b0, 0);
    tmr_pulse(4);
    repeat (2) @(negedge clk); chk_gnt("R10 off-source channel ignores timer", 1'b0, 0);
  endtask

  task automatic t_generic();
    do_reset();
    cfg_wr(1, 8'h44);
    go();
    gen_pulse(1);
    repeat (2) @(negedge clk); chk_gnt("R4 wrong generic input ignored", 1'b0, 0);
    gen_pulse(2);
    @(negedge clk); chk_gnt("R4 generic input 2 grant", 1'b1, 1);
    done_pulse();
  endtask

  task automatic t_prio();
    do_reset();
    cfg_wr(6, 8'h4A);
    cfg_wr(2, 8'h6A);
    go();
    gen_pulse(0);
    @(negedge clk); chk_gnt("R5 urgent level first", 1'b1, 6);
    done_pulse();
    @(negedge clk); chk_gnt("R5 lower level next", 1'b1, 2);
    done_pulse();
  endtask

  task automatic t_rr();
    do_reset();
    cfg_wr(1, 8'h5A); cfg_wr(4, 8'h5A); cfg_wr(6, 8'h5A);
    go();
    gen_pulse(0);
    @(negedge clk); chk_gnt("R6 lowest index first", 1'b1, 1);
    done_pulse();
    @(negedge clk); chk_gnt("R6 next in level", 1'b1, 4);
    gen_pulse(0);
    done_pulse();
    @(negedge clk); chk_gnt("R6 pointer skips lower index", 1'b1, 6);
    done_pulse();
    @(negedge clk); chk_gnt("R6 pointer wraps", 1'b1, 1);
    done_pulse();
    repeat (2) @(negedge clk); chk_gnt("R6 requests drained", 1'b0, 0);
  endtask

  task automatic t_group();
    do_reset();
    cfg_wr(2, 8'h01);
    cfg_wr(3, 8'h00);
    cfg_wr(6, 8'h41);
    go();
    tmr_pulse(2);
    @(negedge clk); chk_gnt("R7 head granted", 1'b1, 2);
    done_pulse(); chk_gnt("R7 step to follower", 1'b1, 3);
    tmr_pulse(6); chk_gnt("R11 no interruption", 1'b1, 3);
    done_pulse(); chk_gnt("R7 step to group end", 1'b1, 4);
    done_pulse(); chk_gnt("R7 group released", 1'b0, 0);
    @(negedge clk); chk_gnt("R11 latched trigger served after group", 1'b1, 6);
    done_pulse();
  endtask

  task automatic t_cont();
    do_reset();
    cfg_wr(5, 8'h67);
    go();
    @(negedge clk); chk_gnt("R8 continuous granted untriggered", 1'b1, 5);
    done_pulse(); chk_gnt("R8 group ends", 1'b0, 0);
    @(negedge clk); chk_gnt("R8 re-armed", 1'b1, 5);
    chk("R9 single continuous no error", 32'(multi_cont_err), 0);
    blk_en = 1'b0;
    cfg_wr(0, 8'h47);
    @(negedge clk);
    chk("R9 two continuous flagged", 32'(multi_cont_err), 1);
    cfg_wr(0, 8'h40);
    @(negedge clk);
    chk("R9 error clears", 32'(multi_cont_err), 0);
  endtask

  task automatic t_disabled();
    do_reset();
    cfg_wr(3, 8'h41);
    blk_en = 1'b1; ch_en = ~(NUM_CH'(1) << 3);
    tmr_pulse(3);
    repeat (2) @(negedge clk); chk_gnt("R10 disabled channel not granted", 1'b0, 0);
    ch_en[3] = 1'b1;
    repeat (2) @(negedge clk); chk_gnt("R10 no stale request", 1'b0, 0);
    tmr_pulse(3);
    @(negedge clk); chk_gnt("R10 enabled channel granted", 1'b1, 3);
    done_pulse();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_cfg_gate();
    t_timer();
    t_generic();
    t_prio();
    t_rr();
    t_group();
    t_cont();
    t_disabled();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule